// File: doc/BRIEF.md
# Partial Timestamp Wraparound Reconstructor

Event timestamps are often captured as only the low N bits of a free-running 64-bit time counter, because a narrow field is cheaper to latch and to carry with a frame. This block turns such a short capture back into a full 64-bit event time. It takes the short value and a fresh reading of the full counter. It keeps the counter's upper bits and puts the short value beneath them. The counter has moved on since the event, so if its low bits now sit at or below the captured value, the low field has rolled over in between. In that case one wrap period, 2^N counts, is taken off the result. The answer is only right when the reading is taken less than one wrap period after the event. With N of 24 the window is roughly 0.135 s; with N of 32 it is roughly 34.35 s.

Alongside the rebuild path sits a single-entry holding register for egress captures. A writer deposits a short timestamp, which raises a pending flag. A consumer polls the register. Each read returns a packed word and lowers the flag. There is no queue: a second capture overwrites the first.

Top module: `ts_wrap_rebuild`

## Requirements
- R1: While rst is high and on the first cycle after it, out_valid, egr_rd_valid and egr_pending are 0, and out_time and egr_rd_word are all zeros.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high, so the path has one cycle of latency.
- R3: When the low N bits of in_now are greater than in_partial, out_time equals in_now with its low N bits replaced by in_partial.
- R4: When the low N bits of in_now equal in_partial, out_time equals that spliced value minus 2^N.
- R5: When the low N bits of in_now are less than in_partial, out_time equals the spliced value minus 2^N, so it is below in_now.
- R6: The subtraction is modulo 2^64: if in_now is below 2^N and a wrap is detected, out_time becomes 2^64 - 2^N + in_partial.
- R7: In a cycle after one with in_valid low, out_time keeps its previous value.
- R8: An egr_wr pulse raises egr_pending in the next cycle, and the flag stays high until a read.
- R9: An egr_rd pulse makes egr_rd_valid high in the next cycle, with egr_rd_word holding the state from before the read. Bit 0 is the pending flag. The stored timestamp fills the top N bits of the word, and every other bit is 0. The word is 32 bits wide when N is at most 24 and 64 bits otherwise. With N = 24 the timestamp is in bits 31:8, and with N = 32 it is in bits 63:32. egr_rd_word holds its value between reads.
- R10: A read lowers egr_pending in the next cycle. If egr_wr is high in the same cycle as egr_rd, the write wins: the flag stays high, and the read returns the word from before the write.
- R11: A second write before any read replaces the stored timestamp. The next read returns only the newer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Rebuild request strobe |
| in_partial | input | TS_W | Captured low bits of the counter at the event |
| in_now | input | TIME_W | Current full counter value |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_time | output | TIME_W | Rebuilt full event time |
| egr_wr | input | 1 | Deposit a new egress capture |
| egr_ts | input | TS_W | Egress capture value |
| egr_rd | input | 1 | Poll read of the holding register |
| egr_rd_valid | output | 1 | Read data strobe |
| egr_rd_word | output | WORD_W | Packed flag and timestamp word |
| egr_pending | output | 1 | Capture waiting to be read |

## Verification
Directed requests put the counter's low bits above, equal to and below the captured value. These separate the plain splice from the one-period correction and catch an off-by-one in the comparison, which the equal case alone exposes. A counter reading below 2^N with a wrap shows whether the subtraction rolls over modulo 2^64. The holding register is tried with lone writes, repeated reads, two writes before a read and a write in the same cycle as a read. These tell overwrite behaviour, flag clearing and write priority apart. A long run of random requests and register traffic is then compared against the reference model every cycle.

// File: rtl/ts_rebuild_pkg.sv
package ts_rebuild_pkg;
  // Width of the packed egress word for a given capture width.
  function automatic int egr_word_width(input int ts_bits);
    return (ts_bits <= 24) ? 32 : 64;
  endfunction
endpackage

// File: rtl/ts_splice_unit.sv
module ts_splice_unit #(
  parameter int TS_W   = 24,
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [TS_W-1:0]   req_partial,
  input  logic [TIME_W-1:0] req_now,
  output logic              res_valid,
  output logic [TIME_W-1:0] res_time
);
  localparam logic [TIME_W-1:0] WRAP_SPAN = {{(TIME_W-1){1'b0}}, 1'b1} << TS_W;

  logic [TS_W-1:0]   now_low;
  logic [TIME_W-1:0] spliced;
  logic              rolled;
  logic [TIME_W-1:0] rebuilt;

  always_comb begin
    now_low = req_now[TS_W-1:0];
    spliced = {req_now[TIME_W-1:TS_W], req_partial};
    rolled  = (now_low <= req_partial);
    rebuilt = rolled ? (spliced - WRAP_SPAN) : spliced;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_time  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_time <= rebuilt;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !$past(rst)) |=> res_valid);
  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && res_valid == res_valid) |=> $stable(res_time));
  // R3
  low_field_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (res_time[TS_W-1:0] == $past(req_partial)));
  // R5
  not_after_now_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_now >= WRAP_SPAN) |=> (res_time < $past(req_now)));
endmodule

// File: rtl/egr_ts_holder.sv
module egr_ts_holder #(
  parameter int TS_W   = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TS_W-1:0]   wr_ts,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word,
  output logic              pending
);
  localparam int PAD_W = WORD_W - TS_W - 1;

  logic [TS_W-1:0]   held_ts;
  logic [WORD_W-1:0] packed_word;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb packed_word = {held_ts, {PAD_W{1'b0}}, pending};
    end else begin : g_nopad
      always_comb packed_word = {held_ts, pending};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      held_ts  <= '0;
      pending  <= 1'b0;
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_word <= packed_word;
      if (wr_en) begin
        held_ts <= wr_ts;
        pending <= 1'b1;
      end else if (rd_en) begin
        pending <= 1'b0;
      end
    end
  end

  // R8
  flag_raise_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> pending);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> !pending);
  // R9
  read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !$past(rst)) |=> rd_valid);
  // R9
  read_flag_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !$past(rst)) |=> (rd_word[0] == $past(pending)));
endmodule

// File: rtl/ts_wrap_rebuild.sv
module ts_wrap_rebuild #(
  parameter int TS_W   = 24,
  parameter int TIME_W = 64,
  parameter int WORD_W = ts_rebuild_pkg::egr_word_width(TS_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TS_W-1:0]   in_partial,
  input  logic [TIME_W-1:0] in_now,
  output logic              out_valid,
  output logic [TIME_W-1:0] out_time,
  input  logic              egr_wr,
  input  logic [TS_W-1:0]   egr_ts,
  input  logic              egr_rd,
  output logic              egr_rd_valid,
  output logic [WORD_W-1:0] egr_rd_word,
  output logic              egr_pending
);
  ts_splice_unit #(.TS_W(TS_W), .TIME_W(TIME_W)) u_splice (
    .clk(clk), .rst(rst),
    .req_valid(in_valid), .req_partial(in_partial), .req_now(in_now),
    .res_valid(out_valid), .res_time(out_time)
  );

  egr_ts_holder #(.TS_W(TS_W), .WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst(rst),
    .wr_en(egr_wr), .wr_ts(egr_ts), .rd_en(egr_rd),
    .rd_valid(egr_rd_valid), .rd_word(egr_rd_word), .pending(egr_pending)
  );
endmodule

// File: tb/ts_wrap_rebuild_test.sv
module ts_wrap_rebuild_test;
  localparam int TS_W = 24;
  localparam int TIME_W = 64;
  localparam int WORD_W = 32;
  localparam logic [63:0] SPAN = 64'd1 << TS_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [TS_W-1:0] in_partial = '0;
  logic [TIME_W-1:0] in_now = '0;
  logic out_valid;
  logic [TIME_W-1:0] out_time;
  logic egr_wr = 1'b0;
  logic [TS_W-1:0] egr_ts = '0;
  logic egr_rd = 1'b0;
  logic egr_rd_valid;
  logic [WORD_W-1:0] egr_rd_word;
  logic egr_pending;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ts_wrap_rebuild uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_partial(in_partial),
    .in_now(in_now), .out_valid(out_valid), .out_time(out_time),
    .egr_wr(egr_wr), .egr_ts(egr_ts), .egr_rd(egr_rd),
    .egr_rd_valid(egr_rd_valid), .egr_rd_word(egr_rd_word),
    .egr_pending(egr_pending)
  );

  // reference model state
  logic m_valid = 0;
  logic [63:0] m_time = 0;
  logic m_pend = 0;
  logic [TS_W-1:0] m_ts = 0;
  logic m_rdv = 0;
  logic [WORD_W-1:0] m_word = 0;
  string time_tag = "R1";
  string rd_tag = "R1";
  string read_tag_req = "R9";

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Advance one clock: compute model from held inputs, then compare.
  task automatic cycle();
    logic [63:0] lo, r;
    if (rst) begin
      m_valid = 0; m_time = 0; m_pend = 0; m_ts = 0; m_rdv = 0; m_word = 0;
      time_tag = "R1"; rd_tag = "R1";
    end else begin
      m_valid = in_valid;
      if (in_valid) begin
        lo = in_now % SPAN;
        r  = (in_now - lo) + 64'(in_partial);
        if (lo > 64'(in_partial)) time_tag = "R3";
        else begin
          r = r - SPAN;
          if (lo == 64'(in_partial)) time_tag = "R4";
          else if (in_now < SPAN) time_tag = "R6";
          else time_tag = "R5";
        end
        m_time = r;
      end else time_tag = "R7";
      m_rdv = egr_rd;
      if (egr_rd) begin
        m_word = (WORD_W'(m_ts) << (WORD_W - TS_W)) | WORD_W'(m_pend);
        rd_tag = (egr_wr) ? "R10" : read_tag_req;
      end
      if (egr_wr) begin m_ts = egr_ts; m_pend = 1; end
      else if (egr_rd) m_pend = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rst ? "R1" : "R2", "out_valid", 64'(out_valid), 64'(m_valid));
    chk(time_tag, "out_time", out_time, m_time);
    chk(rst ? "R1" : "R8", "egr_pending", 64'(egr_pending), 64'(m_pend));
    chk(rst ? "R1" : "R9", "egr_rd_valid", 64'(egr_rd_valid), 64'(m_rdv));
    chk(rd_tag, "egr_rd_word", 64'(egr_rd_word), 64'(m_word));
  endtask

  task automatic idle_inputs();
    in_valid = 0; egr_wr = 0; egr_rd = 0; read_tag_req = "R9";
  endtask

  task automatic rebuild(input logic [63:0] now, input logic [TS_W-1:0] p);
    in_valid = 1; in_now = now; in_partial = p;
    cycle();
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1;
    repeat (3) cycle();            // R1 during reset
    rst = 0;
    cycle();                       // R1 first cycle after reset
    // R3: low bits above capture
    rebuild(64'h0000_0012_3480_0000, 24'h7F_FFFF);
    // R7: idle keeps result
    cycle(); cycle();
    // R4: equal low bits
    rebuild(64'h0000_00AB_CD12_3456, 24'h12_3456);
    // R5: low bits below capture
    rebuild(64'h0000_0100_0000_0010, 24'hFF_FF00);
    // R6: counter below one span
    rebuild(64'h0000_0000_0000_0005, 24'h00_0009);
    // R2: back-to-back requests
    in_valid = 1; in_now = 64'hFFFF_FFFF_FFFF_FFFF; in_partial = 24'h00_0001; cycle();
    in_now = 64'h1; in_partial = 24'h0; cycle();
    idle_inputs(); cycle();
    // R8: write raises flag
    egr_wr = 1; egr_ts = 24'hA5_5A01; cycle(); idle_inputs();
    cycle();
    // R9: read packs word, R10 clears flag
    egr_rd = 1; cycle(); idle_inputs(); cycle();
    egr_rd = 1; cycle(); idle_inputs(); cycle();   // R10 flag now 0 in word
    // R10: write and read together
    egr_wr = 1; egr_rd = 1; egr_ts = 24'h13_5790; cycle(); idle_inputs(); cycle();
    // R11: two writes, then read returns latest
    egr_wr = 1; egr_ts = 24'h11_1111; cycle();
    egr_ts = 24'h22_2222; cycle(); idle_inputs();
    egr_rd = 1; read_tag_req = "R11"; cycle(); idle_inputs(); cycle();
    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      in_valid = $urandom_range(0, 1);
      in_now = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) in_now = in_now >> 40;
      in_partial = TS_W'($urandom);
      if ($urandom_range(0, 4) == 0) in_partial = in_now[TS_W-1:0];
      egr_wr = ($urandom_range(0, 3) == 0);
      egr_ts = TS_W'($urandom);
      egr_rd = ($urandom_range(0, 2) == 0);
      cycle();
    end
    idle_inputs();
    cycle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule